// File: doc/BRIEF.md
# Colour Lookup Table with Register Write Port

This block holds a 256-entry colour palette, with 8-bit red, green and blue values in each entry, and gives it two sides. On the bus side, a 32-bit write port decodes a 16-byte register window. Software first loads a palette index through one register. It then writes the colour components of that entry one after another through a second register. Only the top byte of each written word is used. After the third component, the index steps on by itself, so a whole palette can be loaded with one index write followed by a stream of component writes. Reads of the window always return zero.

On the pixel side, a registered lookup port turns an 8-bit pixel index into a 24-bit colour one clock later. Each component write also raises a one-cycle change pulse. Display logic downstream can use this pulse to schedule a refresh.

Top module: `color_lut_ctrl`

## Requirements
- R1: The register number is bus_addr_i[3:2]. Address bits 1:0 are ignored, so register 0 is hit by offsets 0 to 3, register 1 by offsets 4 to 7, and so on.
- R2: A write to register 0 loads the current index from bus_wdata_i[31:24] and returns the component step to red.
- R3: Successive writes to register 1 store bus_wdata_i[31:24] into the red, then the green, then the blue component of the entry at the current index.
- R4: The write that stores blue moves the index on by one, wrapping from 255 to 0, and returns the component step to red.
- R5: Writes to registers 2 and 3 change neither the palette, nor the index, nor the component step.
- R6: bus_rdata_o is zero at all times.
- R7: After reset the index is 0 and the component step is red. Every palette entry is black (0,0,0), except entry 255, which is white (255,255,255).
- R8: pix_rgb_o shows the entry selected by pix_idx_i at the previous rising clock edge. The layout is red in bits 23:16, green in bits 15:8 and blue in bits 7:0. The output is 0 during reset.
- R9: When a component write and a lookup of the same entry fall in the same cycle, both complete. The lookup returns the value the entry held before the write.
- R10: pal_changed_o is high for exactly the one cycle that follows each write to register 1, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Bus write strobe |
| bus_addr_i | input | 4 | Byte offset inside the register window |
| bus_wdata_i | input | 32 | Write data; only bits 31:24 are used |
| bus_rdata_o | output | 32 | Read data, always zero |
| pix_idx_i | input | 8 | Pixel index to look up |
| pix_rgb_o | output | 24 | Looked-up colour {R,G,B}, one cycle later |
| pal_changed_o | output | 1 | One-cycle pulse after each component write |

## Verification
The assertions check several rules on every cycle:
- the component step never takes its unused code;
- an index write loads the top data byte and restarts at red;
- a blue write moves the index on by exactly one;
- writes to the reserved registers leave the sequencer alone;
- the change pulse only ever follows a data-register write;
- a lookup that collides with a write returns the old component.

Only the bench scenarios can show the rest:
- the reset contents, including the white top entry;
- the full red, green, blue ordering against a palette model;
- the wrap from entry 255 to entry 0;
- the aliasing of the low address bits;
- that reserved writes leave the stored colours untouched.

// File: rtl/clut_pkg.sv
package clut_pkg;
  typedef enum logic [1:0] {
    COMP_RED = 2'd0,
    COMP_GRN = 2'd1,
    COMP_BLU = 2'd2
  } comp_e;

  typedef enum logic [1:0] {
    REG_INDEX = 2'd0,
    REG_DATA  = 2'd1,
    REG_RSV2  = 2'd2,
    REG_RSV3  = 2'd3
  } reg_e;

  localparam int unsigned NUM_COMP = 3;
endpackage

// File: rtl/clut_seq.sv
module clut_seq
  import clut_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4,
  parameter int unsigned IW = 8,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          wr_en_o,
  output comp_e         wr_comp_o,
  output logic [IW-1:0] wr_idx_o,
  output logic [CW-1:0] wr_byte_o
);
  reg_e          reg_sel;
  logic [CW-1:0] top_byte;
  logic [IW-1:0] idx_q;
  comp_e         seq_q;

  assign reg_sel  = reg_e'(addr_i[3:2]);
  assign top_byte = wdata_i[DW-1 -: CW];

  assign wr_en_o   = we_i && (reg_sel == REG_DATA);
  assign wr_comp_o = seq_q;
  assign wr_idx_o  = idx_q;
  assign wr_byte_o = top_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      seq_q <= COMP_RED;
    end else if (we_i && reg_sel == REG_INDEX) begin
      idx_q <= top_byte[IW-1:0];
      seq_q <= COMP_RED;
    end else if (wr_en_o) begin
      if (seq_q == COMP_BLU) begin
        seq_q <= COMP_RED;
        idx_q <= idx_q + 1'b1;
      end else begin
        seq_q <= comp_e'(seq_q + 2'd1);
      end
    end
  end

  AST_SEQ_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_q != 2'd3); // R3

  AST_IDX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[3:2] == 2'd0) |=>
      (idx_q == $past(wdata_i[DW-1 -: IW]) && seq_q == COMP_RED)); // R2

  AST_IDX_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[3:2] == 2'd1 && seq_q == COMP_BLU) |=>
      (idx_q == IW'($past(idx_q) + 1) && seq_q == COMP_RED)); // R4

  AST_RSV_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[3]) |=> ($stable(idx_q) && $stable(seq_q))); // R5
endmodule

// File: rtl/clut_mem.sv
module clut_mem
  import clut_pkg::*;
#(
  parameter int unsigned IW = 8,
  parameter int unsigned CW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  comp_e             wr_comp_i,
  input  logic [IW-1:0]     wr_idx_i,
  input  logic [CW-1:0]     wr_byte_i,
  input  logic [IW-1:0]     rd_idx_i,
  output logic [3*CW-1:0]   rd_rgb_o
);
  localparam int unsigned NE = 1 << IW;

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_plane
    logic [CW-1:0] plane [NE];
    logic [CW-1:0] rd_q;
    logic          hit;

    assign hit = wr_en_i && (wr_comp_i == comp_e'(c));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int e = 0; e < NE; e++) plane[e] <= (e == NE - 1) ? '1 : '0;
      end else if (hit) begin
        plane[wr_idx_i] <= wr_byte_i;
      end
    end

    // registered read: a same-cycle write is seen on the next lookup
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rd_q <= '0;
      else         rd_q <= plane[rd_idx_i];
    end

    assign rd_rgb_o[(NUM_COMP-1-c)*CW +: CW] = rd_q;

    AST_RD_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit && wr_idx_i == rd_idx_i && plane[rd_idx_i] != wr_byte_i) |=>
        (rd_q != $past(wr_byte_i))); // R9
  end
endmodule

// File: rtl/color_lut_ctrl.sv
module color_lut_ctrl
  import clut_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 4,
  parameter int unsigned IW = 8,
  parameter int unsigned CW = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bus_we_i,
  input  logic [AW-1:0]          bus_addr_i,
  input  logic [DW-1:0]          bus_wdata_i,
  output logic [DW-1:0]          bus_rdata_o,
  input  logic [IW-1:0]          pix_idx_i,
  output logic [NUM_COMP*CW-1:0] pix_rgb_o,
  output logic                   pal_changed_o
);
  logic          wr_en;
  comp_e         wr_comp;
  logic [IW-1:0] wr_idx;
  logic [CW-1:0] wr_byte;
  logic          chg_q;

  clut_seq #(.DW(DW), .AW(AW), .IW(IW), .CW(CW)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .wr_en_o   (wr_en),
    .wr_comp_o (wr_comp),
    .wr_idx_o  (wr_idx),
    .wr_byte_o (wr_byte)
  );

  clut_mem #(.IW(IW), .CW(CW)) i_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_comp_i (wr_comp),
    .wr_idx_i  (wr_idx),
    .wr_byte_i (wr_byte),
    .rd_idx_i  (pix_idx_i),
    .rd_rgb_o  (pix_rgb_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chg_q <= 1'b0;
    else         chg_q <= wr_en;
  end

  assign pal_changed_o = chg_q;
  assign bus_rdata_o   = '0;

  AST_CHG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pal_changed_o |-> $past(bus_we_i && bus_addr_i[3:2] == 2'd1)); // R10

  AST_CHG_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_i && bus_addr_i[3:2] == 2'd1) |=> pal_changed_o); // R10
endmodule

// File: tb/test_color_lut_ctrl.sv
`timescale 1ns/1ps
module test_color_lut_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  pix = '0;
  logic [23:0] rgb;
  logic        chg;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m_r [256];
  logic [7:0] m_g [256];
  logic [7:0] m_b [256];
  logic [7:0] m_idx;
  int         m_seq;

  always #4 clk = ~clk;

  color_lut_ctrl i_color_lut_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pix_idx_i(pix),
    .pix_rgb_o(rgb), .pal_changed_o(chg)
  );

  function automatic logic [23:0] exp_rgb(logic [7:0] i);
    return {m_r[i], m_g[i], m_b[i]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_write(logic [3:0] a, logic [31:0] d);
    if (a[3:2] == 2'd0) begin
      m_idx = d[31:24]; m_seq = 0;
    end else if (a[3:2] == 2'd1) begin
      case (m_seq)
        0: m_r[m_idx] = d[31:24];
        1: m_g[m_idx] = d[31:24];
        default: m_b[m_idx] = d[31:24];
      endcase
      if (m_seq == 2) begin m_seq = 0; m_idx = m_idx + 8'd1; end
      else m_seq++;
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    check("R10", {31'd0, chg}, {31'd0, a[3:2] == 2'd1});
    check("R6", rdata, 32'd0);
    model_write(a, d);
  endtask

  task automatic look(logic [7:0] i, string req);
    @(negedge clk);
    pix = i;
    @(negedge clk);
    check(req, {8'd0, rgb}, {8'd0, exp_rgb(i)});
    check("R10", {31'd0, chg}, 32'd0);
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] old;
    void'($urandom(32'd1234));
    for (int e = 0; e < 256; e++) begin
      m_r[e] = (e == 255) ? 8'hFF : 8'h00;
      m_g[e] = m_r[e]; m_b[e] = m_r[e];
    end
    m_idx = 8'd0; m_seq = 0;
    repeat (3) @(negedge clk);
    check("R7", {8'd0, rgb}, 32'd0);
    check("R10", {31'd0, chg}, 32'd0);
    rst_n = 1'b1;
    check("R6", rdata, 32'd0);
    look(8'd0, "R7");
    look(8'd128, "R7");
    look(8'd255, "R7");
    check("R7 white", {8'd0, rgb}, 32'h00FFFFFF);

    // index defaults to 0 after reset: R7 / R3 order
    bus_write(4'h4, 32'h11AAAAAA);
    bus_write(4'h4, 32'h22000000);
    bus_write(4'h4, 32'h33000000);
    look(8'd0, "R3");
    check("R8 layout", {8'd0, rgb}, 32'h00112233);

    // R1: low address bits alias
    bus_write(4'h3, 32'h0A000000);
    bus_write(4'h5, 32'h44000000);
    bus_write(4'h6, 32'h55000000);
    bus_write(4'h7, 32'h66000000);
    look(8'h0A, "R1");

    // R2: index write mid-sequence restarts at red
    bus_write(4'h0, 32'h20000000);
    bus_write(4'h4, 32'h77000000);
    bus_write(4'h0, 32'h21000000);
    bus_write(4'h4, 32'h88000000);
    look(8'h20, "R2");
    look(8'h21, "R2");

    // R5: reserved registers
    bus_write(4'h8, 32'hEE000000);
    bus_write(4'hC, 32'hDD000000);
    look(8'h21, "R5");
    bus_write(4'h4, 32'h99000000);
    look(8'h21, "R5 seq kept");
    look(8'hEE, "R5");
    look(8'hDD, "R5");

    // R4: wrap from 255 to 0
    bus_write(4'h0, 32'hFF000000);
    bus_write(4'h4, 32'h01000000);
    bus_write(4'h4, 32'h02000000);
    bus_write(4'h4, 32'h03000000);
    bus_write(4'h4, 32'hC0000000);
    look(8'hFF, "R4");
    look(8'h00, "R4 wrap");

    // R9: same-cycle write and lookup
    bus_write(4'h0, 32'h40000000);
    @(negedge clk);
    old = exp_rgb(8'h40);
    we = 1'b1; addr = 4'h4; wdata = 32'h5A000000; pix = 8'h40;
    @(negedge clk);
    we = 1'b0;
    check("R9 old", {8'd0, rgb}, {8'd0, old});
    check("R10", {31'd0, chg}, 32'd1);
    model_write(4'h4, 32'h5A000000);
    @(negedge clk);
    check("R9 new", {8'd0, rgb}, {8'd0, exp_rgb(8'h40)});

    // random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned k = $urandom_range(0, 9);
      if (k < 3) look(8'($urandom), "R8");
      else if (k < 8) bus_write(4'($urandom_range(4, 7)), $urandom);
      else bus_write(4'($urandom), $urandom);
    end
    for (int e = 0; e < 256; e += 17) look(8'(e), "R8 sweep");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule